// File: doc/BRIEF.md
# Windowed Interrupt Priority Configuration Bank

This block stores a 3-bit priority level for each of 128 interrupt requests and lets a CPU reach them through a narrow indirect window. A group-select register names one group of eight requests. Eight window registers then read and write the priority of those eight requests. Window slot 0 maps to the lowest vector of the group and slot 7 to the highest. The group number is the upper nibble of the low byte of the vector address. Vectors sit 2 bytes apart, so one 16-byte stretch of vector addresses holds exactly one group.

The bus is a plain synchronous register port. Writes take effect on the rising clock edge. Read data is a combinational function of the address and the stored state. Word addresses 0 to 7 are the window slots, address 8 is the group-select register, and addresses 9 to 15 are unmapped. Group 0 has no storage behind it. While it is selected, the window discards writes and reads as zero.

For a downstream arbiter, the block drives every request's priority on a flat bus, together with one enable bit per request.

Top module: `irq_prio_bank`

## Requirements
- R1: The group-select register sits at address 8. Write data bits 7:4 are stored as the group number. Reads return the group in bits 7:4 and zero in bits 3:0. The register clears to 0 on reset.
- R2: A write to window address k (0 to 7) with a nonzero group g sets the level of request g*8+k to write data bits 2:0, on the next rising edge. No other request changes.
- R3: A read of window address k with a nonzero group g returns the level of request g*8+k in bits 2:0 and zero in bits 7:3.
- R4: While the group is 0, window writes are discarded and window reads return 0. Requests 0 to 7 always report level 0.
- R5: After reset, every request from 8 to 127 holds level 1 and requests 0 to 7 hold level 0.
- R6: Output prioOut carries the level of request n in bits n*3+2 down to n*3. reqEnable[n] is 1 exactly when that level is nonzero.
- R7: Writing level 0 to a request disables it: its reqEnable bit drops to 0. A later nonzero write enables it again.
- R8: Addresses 9 to 15 read as 0, and writes to them change neither the select register nor any level.
- R9: A change of group takes effect on the access that follows the select write. Levels written earlier in another group are kept and read back unchanged when that group is selected again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 4 | Word address: 0-7 window, 8 select, 9-15 unmapped |
| busWe | input | 1 | Write enable for the addressed register |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr |
| prioOut | output | 384 | Level of request n at bits n*3 +: 3 |
| reqEnable | output | 128 | Request n enabled (level nonzero) |

## Verification
The bench builds the block with its default parameters: 128 requests, 3-bit levels, an 8-bit data bus and a 4-bit address. With these values it can sweep all fifteen live groups and all eight slots in each. It can also observe the hard-wired group 0, the ignored low nibble of the select register and the whole unmapped address range. Every one of the 128 output lanes and enable bits is compared after reset and again after a fill with a distinct pattern in every group. The fill includes level 0 entries, so the disable path is covered.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  // eight requests are visible through the window at once
  localparam int unsigned WinIdxW = 3;
  localparam int unsigned WinSlots = 1 << WinIdxW;
  // width of one priority level
  localparam int unsigned LvlW = 3;

  typedef struct packed {
    logic               winWr;   // commit a level to the selected entry
    logic               winRd;   // window read is live (group nonzero)
    logic               selRd;   // read of the group-select register
    logic [WinIdxW-1:0] winIdx;  // slot inside the group
    logic [LvlW-1:0]    wrLvl;   // level to commit
  } ctrlStrobes_t;
endpackage

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_REQ = 128,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ADDR_W  = 4,
  localparam int unsigned NumGroups = NUM_REQ / WinSlots,
  localparam int unsigned SelW = $clog2(NumGroups),
  localparam int unsigned EntW = SelW + WinIdxW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output ctrlStrobes_t      strb,
  output logic [EntW-1:0]   entIdx,
  output logic [DATA_W-1:0] selRdData
);
  localparam logic [ADDR_W-1:0] SelAddr = ADDR_W'(WinSlots);

  logic [SelW-1:0] selQ;
  logic winHit;
  logic selHit;
  logic deadWin;

  assign winHit  = busAddr < SelAddr;
  assign selHit  = busAddr == SelAddr;
  assign deadWin = selQ == '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ <= '0;
    end else if (busWe && selHit) begin
      selQ <= busWdata[DATA_W-1 -: SelW];
    end
  end

  always_comb begin
    strb        = '0;
    strb.winWr  = busWe && winHit && !deadWin;
    strb.winRd  = winHit && !deadWin;
    strb.selRd  = selHit;
    strb.winIdx = busAddr[WinIdxW-1:0];
    strb.wrLvl  = busWdata[LvlW-1:0];
  end

  assign entIdx    = {selQ, strb.winIdx};
  assign selRdData = {selQ, {(DATA_W-SelW){1'b0}}};
endmodule

// File: rtl/irq_prio_store.sv
module irq_prio_store
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_REQ = 128,
  parameter int unsigned DATA_W  = 8,
  localparam int unsigned EntW = $clog2(NUM_REQ)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobes_t            strb,
  input  logic [EntW-1:0]         entIdx,
  output logic [DATA_W-1:0]       winRdData,
  output logic [NUM_REQ*LvlW-1:0] prioOut,
  output logic [NUM_REQ-1:0]      reqEnable
);
  logic [LvlW-1:0] entry [NUM_REQ];

  for (genvar n = 0; n < NUM_REQ; n++) begin : g_ent
    if (n < WinSlots) begin : g_dead
      // group 0 has no storage
      assign entry[n] = '0;
    end else begin : g_live
      logic [LvlW-1:0] lvlQ;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          lvlQ <= LvlW'(1);
        end else if (strb.winWr && entIdx == EntW'(n)) begin
          lvlQ <= strb.wrLvl;
        end
      end
      assign entry[n] = lvlQ;
    end
    assign prioOut[n*LvlW +: LvlW] = entry[n];
    assign reqEnable[n]            = |entry[n];
  end

  always_comb begin
    winRdData = '0;
    if (strb.winRd) begin
      winRdData[LvlW-1:0] = entry[entIdx];
    end
  end
endmodule

// File: rtl/irq_prio_bank.sv
module irq_prio_bank
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_REQ = 128,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ADDR_W  = 4,
  localparam int unsigned EntW = $clog2(NUM_REQ)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic                    busWe,
  input  logic [DATA_W-1:0]       busWdata,
  output logic [DATA_W-1:0]       busRdata,
  output logic [NUM_REQ*LvlW-1:0] prioOut,
  output logic [NUM_REQ-1:0]      reqEnable
);
  ctrlStrobes_t      strb;
  logic [EntW-1:0]   entIdx;
  logic [DATA_W-1:0] selRdData;
  logic [DATA_W-1:0] winRdData;

  irq_prio_ctrl #(
    .NUM_REQ(NUM_REQ), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .strb(strb), .entIdx(entIdx),
    .selRdData(selRdData)
  );

  irq_prio_store #(
    .NUM_REQ(NUM_REQ), .DATA_W(DATA_W)
  ) u_store (
    .clk(clk), .rstN(rstN), .strb(strb), .entIdx(entIdx),
    .winRdData(winRdData), .prioOut(prioOut), .reqEnable(reqEnable)
  );

  assign busRdata = strb.selRd ? selRdData : winRdData;
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_REQ = 128,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ADDR_W  = 4,
  localparam int unsigned SelW = $clog2(NUM_REQ / WinSlots),
  localparam int unsigned EntW = $clog2(NUM_REQ)
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [ADDR_W-1:0]       busAddr,
  input logic                    busWe,
  input logic [DATA_W-1:0]       busWdata,
  input logic [DATA_W-1:0]       busRdata,
  input logic [NUM_REQ*LvlW-1:0] prioOut,
  input logic [NUM_REQ-1:0]      reqEnable
);
  localparam logic [ADDR_W-1:0] SelAddr = ADDR_W'(WinSlots);

  // shadow of the group number, tracked from bus traffic only
  logic [SelW-1:0] selSh;
  logic            wrPend;
  logic [EntW-1:0] wrIdx;
  logic [LvlW-1:0] wrVal;
  logic [LvlW-1:0] rdLane;
  logic [LvlW-1:0] wrLane;
  logic [NUM_REQ-1:0] laneNz;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selSh  <= '0;
      wrPend <= 1'b0;
      wrIdx  <= '0;
      wrVal  <= '0;
    end else begin
      if (busWe && busAddr == SelAddr) selSh <= busWdata[DATA_W-1 -: SelW];
      wrPend <= busWe && busAddr < SelAddr && selSh != '0;
      wrIdx  <= {selSh, busAddr[WinIdxW-1:0]};
      wrVal  <= busWdata[LvlW-1:0];
    end
  end

  always_comb begin
    rdLane = prioOut[{selSh, busAddr[WinIdxW-1:0]}*LvlW +: LvlW];
    wrLane = prioOut[wrIdx*LvlW +: LvlW];
    for (int n = 0; n < NUM_REQ; n++) laneNz[n] = |prioOut[n*LvlW +: LvlW];
  end

  p_sel_low_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    busAddr == SelAddr |-> busRdata == {selSh, {(DATA_W-SelW){1'b0}}});

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrPend |-> wrLane == wrVal);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busWe |=> $stable(prioOut));

  p_read_lane_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr < SelAddr && selSh != '0) |-> busRdata == DATA_W'(rdLane));

  p_dead_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr < SelAddr && selSh == '0) |-> busRdata == '0);

  p_dead_lanes_r4: assert property (@(posedge clk) disable iff (!rstN)
    prioOut[WinSlots*LvlW-1:0] == '0);

  p_enable_r6: assert property (@(posedge clk) disable iff (!rstN)
    reqEnable == laneNz);

  p_unmapped_r8: assert property (@(posedge clk) disable iff (!rstN)
    busAddr > SelAddr |-> busRdata == '0);
endmodule

bind irq_prio_bank irq_prio_chk #(
  .NUM_REQ(NUM_REQ), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
  .busWdata(busWdata), .busRdata(busRdata), .prioOut(prioOut),
  .reqEnable(reqEnable)
);

// File: tb/sim_irq_prio_bank.sv
`timescale 1ns/100ps
module sim_irq_prio_bank;
  localparam int NReq = 128;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [3:0]       busAddr = '0;
  logic             busWe = 1'b0;
  logic [7:0]       busWdata = '0;
  logic [7:0]       busRdata;
  logic [NReq*3-1:0] prioOut;
  logic [NReq-1:0]  reqEnable;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  irq_prio_bank u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .prioOut(prioOut),
    .reqEnable(reqEnable)
  );

  // vector: {we, addr, wdata, expected read}; writes ignore the last field
  localparam int NVec = 19;
  localparam logic [20:0] Vec [NVec] = '{
    {1'b1, 4'd8,  8'h35, 8'h00},  // R1 select group 3, low nibble dropped
    {1'b0, 4'd8,  8'h00, 8'h30},  // R1
    {1'b1, 4'd2,  8'hFD, 8'h00},  // R2 entry 26 <- 5
    {1'b0, 4'd2,  8'h00, 8'h05},  // R3
    {1'b0, 4'd3,  8'h00, 8'h01},  // R5 untouched entry 27
    {1'b1, 4'd7,  8'h00, 8'h00},  // R7 entry 31 <- 0
    {1'b0, 4'd7,  8'h00, 8'h00},  // R7
    {1'b1, 4'd8,  8'hE0, 8'h00},  // R9 group 14
    {1'b0, 4'd2,  8'h00, 8'h01},  // R9 entry 114 still reset
    {1'b1, 4'd0,  8'h07, 8'h00},  // R2 entry 112 <- 7
    {1'b0, 4'd0,  8'h00, 8'h07},  // R3
    {1'b1, 4'd8,  8'h30, 8'h00},  // R9 back to group 3
    {1'b0, 4'd2,  8'h00, 8'h05},  // R9 kept
    {1'b1, 4'd8,  8'h0F, 8'h00},  // R4 group 0
    {1'b1, 4'd1,  8'h06, 8'h00},  // R4 discarded
    {1'b0, 4'd1,  8'h00, 8'h00},  // R4 reads zero
    {1'b0, 4'd9,  8'h00, 8'h00},  // R8
    {1'b1, 4'd12, 8'hFF, 8'h00},  // R8 write ignored
    {1'b0, 4'd8,  8'h00, 8'h00}   // R1/R8 select still 0
  };

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [7:0] v);
    busWe = 1'b0;
    busAddr = a;
    #1;
    v = busRdata;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  function automatic int lane(input int n);
    return int'(prioOut[n*3 +: 3]);
  endfunction

  task automatic checkResetState(input string tag);
    for (int n = 0; n < NReq; n++) begin
      check({tag, " R5 level"}, lane(n), (n < 8) ? 0 : 1);
      check({tag, " R6 enable"}, int'(reqEnable[n]), (n < 8) ? 0 : 1);
    end
  endtask

  function automatic int fillVal(input int g, input int i);
    return (g + i) % 8;
  endfunction

  initial begin
    logic [7:0] rv;
    doReset();
    #1;
    checkResetState("reset");
    busRead(4'd8, rv);
    check("R1 select reset", rv, 0);

    for (int k = 0; k < NVec; k++) begin
      if (Vec[k][20]) begin
        busWrite(Vec[k][19:16], Vec[k][15:8]);
      end else begin
        busRead(Vec[k][19:16], rv);
        check($sformatf("vector %0d R1/R2/R3/R4/R7/R8/R9", k), rv, Vec[k][7:0]);
      end
    end
    check("R6 lane 26", lane(26), 5);
    check("R7 enable 31 off", int'(reqEnable[31]), 0);
    check("R6 lane 112", lane(112), 7);
    check("R4 lane 1", lane(1), 0);
    check("R8 lane 12-untouched 127", lane(127), 1);

    // R7 re-enable
    busWrite(4'd8, 8'h30);
    busWrite(4'd7, 8'h04);
    check("R7 re-enable 31", int'(reqEnable[31]), 1);

    // fill every live group with a distinct pattern
    for (int g = 1; g < 16; g++) begin
      busWrite(4'd8, 8'(g << 4));
      for (int i = 0; i < 8; i++) busWrite(4'(i), 8'(fillVal(g, i) | 8'hF8));
    end
    for (int g = 1; g < 16; g++) begin
      busWrite(4'd8, 8'(g << 4));
      for (int i = 0; i < 8; i++) begin
        busRead(4'(i), rv);
        check($sformatf("R3 readback g%0d s%0d", g, i), rv, fillVal(g, i));
      end
    end
    for (int n = 0; n < NReq; n++) begin
      int e;
      e = (n < 8) ? 0 : fillVal(n / 8, n % 8);
      check($sformatf("R2 lane %0d", n), lane(n), e);
      check($sformatf("R6 enable %0d", n), int'(reqEnable[n]), (e != 0) ? 1 : 0);
    end

    // group 0 stays inert through every slot
    busWrite(4'd8, 8'h00);
    for (int i = 0; i < 8; i++) begin
      busWrite(4'(i), 8'h07);
      busRead(4'(i), rv);
      check("R4 dead window read", rv, 0);
    end
    check("R4 dead lanes", int'(prioOut[23:0]), 0);

    // unmapped range writes leave all state alone
    busWrite(4'd8, 8'h50);
    for (int a = 9; a < 16; a++) begin
      busWrite(4'(a), 8'h00);
      busRead(4'(a), rv);
      check("R8 unmapped read", rv, 0);
    end
    busRead(4'd8, rv);
    check("R8 select kept", rv, 8'h50);
    busRead(4'd3, rv);
    check("R8 entry 43 kept", rv, fillVal(5, 3));

    doReset();
    #1;
    checkResetState("re-reset");
    busRead(4'd8, rv);
    check("R1 select re-reset", rv, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule